// File: doc/BRIEF.md
# Dual 24-bit Time Base Counter

This block keeps two free-running 24-bit counters that other timer logic uses as its time reference for input capture and output match. Each counter picks its own advance source: the system clock divided by a programmable prescaler, rising edges on a shared external clock pin, or (second counter only) a one-cycle angle tick that follows a rotating shaft. A fourth source code parks the counter.

Software can overwrite either counter at any time through a load port. A load wins over an increment in the same cycle and restarts that counter's prescaler. A per-counter enable freezes both the count and the prescaler position. Both counts are always visible on one concatenated broadcast bus for neighbouring timer blocks.

Top module: `dual_timebase`

## Requirements
- R1: After reset both counters read zero on `tb_bus`.
- R2: With source code 0 and divide field N, a counter advances by one every N+1 clock cycles, counted from a load. With N = 0 it advances every cycle.
- R3: With source code 1, a counter advances by one for each rising edge of `ext_clk_pin`, three clock edges after the pin goes high. A held high level and a falling edge do not advance it.
- R4: With source code 2, counter 1 advances by one on each clock edge where `angle_tick` is high.
- R5: Counter 0 treats source code 2 like code 3. In both cases it holds its value whatever `angle_tick` and `ext_clk_pin` do. Counter 1 also holds under code 3.
- R6: While its bit in `tb_en` is 0, a counter keeps its value and its prescaler position. On re-enable, counting resumes from the frozen prescaler position.
- R7: When its bit in `load_en` is 1, a counter takes `load_val` at the next edge instead of incrementing, and its prescaler restarts from zero.
- R8: A counter at 0xFFFFFF goes to 0x000000 on its next advance.
- R9: `tb_bus[23:0]` carries counter 0 and `tb_bus[47:24]` carries counter 1.
- R10: The two counters use their sources, divide fields and enables independently of each other.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset; clears both counters, the prescalers and the pin synchronizer |
| tb_en | input | 2 | Per-counter run enable; bit i controls counter i |
| tb0_src | input | 2 | Counter 0 source: 0 prescaled clock, 1 pin edges, 2 and 3 hold |
| tb1_src | input | 2 | Counter 1 source: 0 prescaled clock, 1 pin edges, 2 angle tick, 3 hold |
| tb0_div | input | 6 | Counter 0 divide field N (divides by N+1) |
| tb1_div | input | 6 | Counter 1 divide field N (divides by N+1) |
| ext_clk_pin | input | 1 | Asynchronous external clock pin, shared by both counters |
| angle_tick | input | 1 | Single-cycle angle tick, synchronous to clk |
| load_en | input | 2 | Per-counter load strobe |
| load_val | input | 24 | Value written by a load |
| tb_bus | output | 48 | Broadcast of both counts, counter 1 in the upper half |

## Verification
The assertions take `angle_tick`, `load_en`, `load_val` and the configuration inputs to be synchronous to `clk`. The only input they allow to be asynchronous is `ext_clk_pin`, which passes through the synchronizer before any check sees it. The rule that a counter changes by at most one per cycle also assumes that each pin pulse, high and low, lasts at least two clock cycles. Without that, edges could be merged or lost in the synchronizer. The bench changes every input only on falling clock edges and keeps each pin level for four or more cycles. It checks counts only after the three-edge pin latency has passed.

// File: rtl/tbase_pkg.sv
package tbase_pkg;
   typedef enum logic [1:0] {
      SRC_SYSCLK = 2'd0,
      SRC_PIN    = 2'd1,
      SRC_ANGLE  = 2'd2,
      SRC_HOLD   = 2'd3
   } tb_src_e;
endpackage

// File: rtl/tbase_pin_sync.sv
module tbase_pin_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_async,
   output logic pin_rise
);
   localparam int LAST = STAGES - 1;

   logic [LAST:0] sync_q;
   logic          prev_q;

   if (STAGES < 2) begin : g_bad_stages
      $error("tbase_pin_sync: STAGES must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q <= '0;
         prev_q <= 1'b0;
      end else begin
         sync_q <= {sync_q[LAST-1:0], pin_async};
         prev_q <= sync_q[LAST];
      end
   end

   assign pin_rise = sync_q[LAST] & ~prev_q;

   // R3: a detected edge lasts exactly one cycle
   p_rise_single_r3 : assert property (@(posedge clk) disable iff (!rst_n)
      pin_rise |=> !pin_rise);
endmodule

// File: rtl/tbase_prescaler.sv
module tbase_prescaler #(
   parameter int DIV_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             restart,
   input  logic [DIV_W-1:0] div,
   output logic             term
);
   logic [DIV_W-1:0] phase_q;
   logic             at_end;

   assign at_end = (phase_q >= div);
   assign term   = run & at_end;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= '0;
      end else if (restart) begin
         phase_q <= '0;
      end else if (run) begin
         if (at_end) phase_q <= '0;
         else        phase_q <= phase_q + 1'b1;
      end
   end

   // R7: a load restarts the divider
   p_restart_clears_r7 : assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> (phase_q == '0));
   // R6: a stopped divider keeps its position
   p_phase_frozen_r6 : assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !restart) |=> $stable(phase_q));
endmodule

// File: rtl/tbase_counter.sv
module tbase_counter
   import tbase_pkg::*;
#(
   parameter int CNT_W     = 24,
   parameter int DIV_W     = 6,
   parameter bit HAS_ANGLE = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic [1:0]       src,
   input  logic [DIV_W-1:0] div,
   input  logic             pin_rise,
   input  logic             angle_tick,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic [CNT_W-1:0] count
);
   tb_src_e          src_e;
   logic             pre_term;
   logic             angle_step;
   logic             step;
   logic [CNT_W-1:0] count_q;

   assign src_e = tb_src_e'(src);

   tbase_prescaler #(.DIV_W(DIV_W)) u_pre (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (en && (src_e == SRC_SYSCLK)),
      .restart (load),
      .div     (div),
      .term    (pre_term)
   );

   if (HAS_ANGLE) begin : g_angle
      assign angle_step = (src_e == SRC_ANGLE) & angle_tick;
   end else begin : g_no_angle
      assign angle_step = 1'b0;
   end

   assign step = en & (((src_e == SRC_SYSCLK) & pre_term) |
                       ((src_e == SRC_PIN)    & pin_rise) |
                       angle_step);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    count_q <= '0;
      else if (load) count_q <= load_val;
      else if (step) count_q <= count_q + 1'b1;
   end

   assign count = count_q;

   // R7: a load lands on the next edge
   p_load_lands_r7 : assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (count == $past(load_val)));
   // R6: disabled counter holds
   p_disabled_holds_r6 : assert property (@(posedge clk) disable iff (!rst_n)
      (!en && !load) |=> $stable(count));
   // R8: without a load the count moves by at most one, wrapping modulo 2^CNT_W
   p_unit_step_r8 : assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> ((count == $past(count)) || (count == CNT_W'($past(count) + 1'b1))));
   // R5: hold code never moves the count
   p_hold_code_r5 : assert property (@(posedge clk) disable iff (!rst_n)
      (src_e == SRC_HOLD && !load) |=> $stable(count));

   if (!HAS_ANGLE) begin : g_no_angle_chk
      // R5: angle code is inert on a counter without angle input
      p_angle_inert_r5 : assert property (@(posedge clk) disable iff (!rst_n)
         (src_e == SRC_ANGLE && !load) |=> $stable(count));
   end
endmodule

// File: rtl/dual_timebase.sv
module dual_timebase #(
   parameter int CNT_W       = 24,
   parameter int DIV_W       = 6,
   parameter int SYNC_STAGES = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [1:0]         tb_en,
   input  logic [1:0]         tb0_src,
   input  logic [1:0]         tb1_src,
   input  logic [DIV_W-1:0]   tb0_div,
   input  logic [DIV_W-1:0]   tb1_div,
   input  logic               ext_clk_pin,
   input  logic               angle_tick,
   input  logic [1:0]         load_en,
   input  logic [CNT_W-1:0]   load_val,
   output logic [2*CNT_W-1:0] tb_bus
);
   localparam int N_TB = 2;

   if (CNT_W < 2) begin : g_bad_cnt
      $error("dual_timebase: CNT_W must be at least 2");
   end
   if (DIV_W < 1) begin : g_bad_div
      $error("dual_timebase: DIV_W must be at least 1");
   end

   logic             pin_rise;
   logic [1:0]       src_arr [N_TB];
   logic [DIV_W-1:0] div_arr [N_TB];
   logic [CNT_W-1:0] cnt_arr [N_TB];

   assign src_arr[0] = tb0_src;
   assign src_arr[1] = tb1_src;
   assign div_arr[0] = tb0_div;
   assign div_arr[1] = tb1_div;

   tbase_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk       (clk),
      .rst_n     (rst_n),
      .pin_async (ext_clk_pin),
      .pin_rise  (pin_rise)
   );

   for (genvar i = 0; i < N_TB; i++) begin : g_tb
      tbase_counter #(
         .CNT_W     (CNT_W),
         .DIV_W     (DIV_W),
         .HAS_ANGLE (i == 1)
      ) u_cnt (
         .clk        (clk),
         .rst_n      (rst_n),
         .en         (tb_en[i]),
         .src        (src_arr[i]),
         .div        (div_arr[i]),
         .pin_rise   (pin_rise),
         .angle_tick (angle_tick),
         .load       (load_en[i]),
         .load_val   (load_val),
         .count      (cnt_arr[i])
      );
      assign tb_bus[i*CNT_W +: CNT_W] = cnt_arr[i];
   end

   // R1: both halves of the bus are zero right after reset
   p_reset_zero_r1 : assert property (@(posedge clk)
      $rose(rst_n) |-> (tb_bus == '0));
endmodule

// File: tb/dual_timebase_tb_top.sv
module dual_timebase_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  tb_en = 2'b00;
   logic [1:0]  tb0_src = 2'd3;
   logic [1:0]  tb1_src = 2'd3;
   logic [5:0]  tb0_div = '0;
   logic [5:0]  tb1_div = '0;
   logic        ext_clk_pin = 1'b0;
   logic        angle_tick = 1'b0;
   logic [1:0]  load_en = 2'b00;
   logic [23:0] load_val = '0;
   logic [47:0] tb_bus;

   int n_checks = 0;
   int n_fails  = 0;
   bit done     = 1'b0;

   always #10ns clk = ~clk;

   dual_timebase dut_i (
      .clk(clk), .rst_n(rst_n), .tb_en(tb_en),
      .tb0_src(tb0_src), .tb1_src(tb1_src),
      .tb0_div(tb0_div), .tb1_div(tb1_div),
      .ext_clk_pin(ext_clk_pin), .angle_tick(angle_tick),
      .load_en(load_en), .load_val(load_val), .tb_bus(tb_bus)
   );

   function automatic logic [23:0] c0(); return tb_bus[23:0];  endfunction
   function automatic logic [23:0] c1(); return tb_bus[47:24]; endfunction

   task automatic chk(string req, logic [47:0] act, logic [47:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic run(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic do_load(logic [1:0] mask, logic [23:0] val);
      load_en  = mask;
      load_val = val;
      @(negedge clk);
      load_en = 2'b00;
   endtask

   task automatic pin_pulses(int n);
      for (int k = 0; k < n; k++) begin
         ext_clk_pin = 1'b1; run(4);
         ext_clk_pin = 1'b0; run(4);
      end
   endtask

   task automatic t_reset();
      chk("R1 counter0 after reset", c0(), 0);
      chk("R1 counter1 after reset", c1(), 0);
   endtask

   task automatic t_sysclk();
      tb_en = 2'b11; tb0_src = 2'd0; tb1_src = 2'd0; tb0_div = 6'd0; tb1_div = 6'd3;
      do_load(2'b11, 24'd0);
      chk("R7 load zero counter0", c0(), 0);
      run(12);
      chk("R2 divide-by-1", c0(), 12);
      chk("R2 R10 divide-by-4 on counter1", c1(), 3);
      chk("R9 bus layout", tb_bus, {24'd3, 24'd12});
   endtask

   task automatic t_pin_angle();
      tb0_src = 2'd1; tb1_src = 2'd2;
      do_load(2'b11, 24'd0);
      pin_pulses(3);
      for (int k = 0; k < 5; k++) begin
         angle_tick = 1'b1; run(1); angle_tick = 1'b0; run(2);
      end
      chk("R3 pin edges counted", c0(), 3);
      chk("R4 angle ticks counted", c1(), 5);
      ext_clk_pin = 1'b1; run(3);
      chk("R3 three-edge latency", c0(), 4);
      run(10);
      chk("R3 held level counts once", c0(), 4);
      ext_clk_pin = 1'b0; run(6);
      chk("R3 falling edge no count", c0(), 4);
   endtask

   task automatic t_ignore();
      logic [23:0] v0, v1;
      tb0_src = 2'd2; tb1_src = 2'd3;
      do_load(2'b11, 24'h00_0040);
      v0 = c0(); v1 = c1();
      for (int k = 0; k < 4; k++) begin
         angle_tick = 1'b1; run(1); angle_tick = 1'b0; run(1);
      end
      pin_pulses(2);
      chk("R5 counter0 ignores angle code", c0(), v0);
      chk("R5 counter1 holds on code 3", c1(), v1);
   endtask

   task automatic t_enable();
      tb0_src = 2'd0; tb0_div = 6'd4; tb1_src = 2'd3;
      do_load(2'b01, 24'd0);
      run(7);
      chk("R2 divide-by-5 partial", c0(), 1);
      tb_en = 2'b10; run(10);
      chk("R6 frozen while disabled", c0(), 1);
      tb_en = 2'b11; run(2);
      chk("R6 prescaler position kept", c0(), 1);
      run(1);
      chk("R6 resumes at frozen phase", c0(), 2);
   endtask

   task automatic t_load_prio();
      tb0_src = 2'd0; tb0_div = 6'd0;
      do_load(2'b01, 24'h12_3456);
      chk("R7 load beats increment", c0(), 24'h12_3456);
      run(1);
      chk("R7 counts on after load", c0(), 24'h12_3457);
      tb1_src = 2'd0; tb1_div = 6'd2;
      do_load(2'b10, 24'd0);
      run(1);
      do_load(2'b10, 24'h10);
      run(2);
      chk("R7 prescaler restarted (2 edges)", c1(), 24'h10);
      run(1);
      chk("R7 prescaler restarted (3 edges)", c1(), 24'h11);
   endtask

   task automatic t_wrap();
      tb0_src = 2'd0; tb0_div = 6'd0;
      do_load(2'b01, 24'hFF_FFFE);
      run(1);
      chk("R8 reaches max", c0(), 24'hFF_FFFF);
      run(1);
      chk("R8 wraps to zero", c0(), 24'h0);
   endtask

   initial begin
      run(3);
      rst_n = 1'b1;
      run(1);
      t_reset();
      t_sysclk();
      t_pin_angle();
      t_ignore();
      t_enable();
      t_load_prio();
      t_wrap();
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
         $finish;
      end
   end

   initial begin
      #(20ns * 50000);
      if (!done) begin
         done = 1'b1;
         n_checks++; n_fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
         $finish;
      end
   end
endmodule